// File: doc/BRIEF.md
# Cluster Performance-State Register Target

This block is the register-side model of one CPU cluster's performance-state controller. It sits on a simple register bus with an address, a write enable, write data and combinational read data. Software asks for a new state by writing the command register. It can then poll a busy flag, and it reads back the state the cluster is running at.

A command write that carries the apply bit starts a transition. While the transition runs, the busy flag reads high. The transition lasts a fixed number of cycles, set by a parameter. When it completes, the requested state becomes the active state. The active state is driven on an output port so that the clock and voltage logic can consume it.

A format parameter chooses where the status register reports the active state. It can be a narrow field, a wide field, or no field at all. With no field, software reads the active state from the primary field of the command register instead.

Top module: `cluster_pstate_regblk`

## Requirements
- R1: After reset the busy flag (command bit 31) is 0, the active state is 0, and both registers read as all zeros.
- R2: The command register (byte address 0x20) reads busy in bit 31 and the stored secondary request in bits 16:12. It reads the primary field in bits 4:0. The apply bit (bit 25) and every other bit read as 0.
- R3: A command write with bit 25 set, accepted while idle, makes busy read 1 from the next cycle for exactly TRANS_CYCLES cycles.
- R4: The active state takes the primary request (write bits 4:0) on the same clock edge at which busy falls. It does not change at any other time.
- R5: A command write accepted while idle with bit 25 clear stores the primary and secondary fields. It starts no transition and leaves the active state unchanged.
- R6: While busy is 1, every command write is ignored. Its fields are not stored, and the state it requests is never applied.
- R7: With the wide format, the status register (byte address 0x50) carries the active state in bits 9:5. With the narrow format, it carries the low 4 bits of the active state in bits 7:4. With no status field, status reads 0 and command bits 4:0 read the active state; with the other formats they read the stored primary request.
- R8: Reads of any other address return 0. Writes to the status register or to other addresses change no state.
- R9: An apply write accepted in the cycle right after busy falls starts a new transition with no dead cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address of the register access |
| wr_en | input | 1 | Write strobe for the current cycle |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Read data for `addr`, combinational |
| cur_state | output | 5 | Active performance-state index |

## Verification
The hardest situation to reach is a second apply write that lands while a transition is still running. The block must drop it entirely: it must not store its fields, and it must not queue its state for later. The stimulus reaches this case by issuing a second command one cycle after an accepted apply. Once busy clears, the bench confirms that the active state and the secondary field still hold the first request. The boundary where busy falls is reached by writing again in the very next cycle, which shows that the second transition starts without any gap.

// File: rtl/pstate_pkg.sv
package pstate_pkg;
   localparam int REG_W      = 64;
   localparam int PS_W       = 5;
   localparam int CMD_OFS    = 'h20;
   localparam int STAT_OFS   = 'h50;
   localparam int BUSY_BIT   = 31;
   localparam int SET_BIT    = 25;
   localparam int PRI_LSB    = 0;
   localparam int SEC_LSB    = 12;
   localparam int NARROW_LSB = 4;
   localparam int NARROW_W   = 4;
   localparam int WIDE_LSB   = 5;
   localparam int WIDE_W     = 5;

   typedef enum logic [1:0] {
      FMT_NONE    = 2'd0,
      FMT_NARROW4 = 2'd1,
      FMT_WIDE5   = 2'd2
   } stat_fmt_e;
endpackage

// File: rtl/pstate_timer.sv
module pstate_timer #(
   parameter int TRANS_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic finish
);
   localparam int CW = (TRANS_CYCLES > 1) ? $clog2(TRANS_CYCLES) : 1;

   if (TRANS_CYCLES < 1) begin : g_bad_len
      $error("pstate_timer: TRANS_CYCLES must be at least 1");
   end

   logic          busy_q;
   logic [CW-1:0] cnt_q;

   // last busy cycle is the one whose count has reached zero
   assign finish = busy_q && (cnt_q == '0);
   assign busy   = busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start && !busy_q) begin
         busy_q <= 1'b1;
         cnt_q  <= CW'(TRANS_CYCLES - 1);
      end else if (finish) begin
         busy_q <= 1'b0;
      end else if (busy_q) begin
         cnt_q  <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/pstate_status_fmt.sv
module pstate_status_fmt
   import pstate_pkg::*;
#(
   parameter stat_fmt_e STAT_FMT = FMT_WIDE5
) (
   input  logic [PS_W-1:0]  cur_state,
   input  logic [PS_W-1:0]  req_pri,
   output logic [REG_W-1:0] stat_word,
   output logic [PS_W-1:0]  pri_view
);
   // some formats leave input bits unread
   logic unused_fmt_in;
   assign unused_fmt_in = ^{cur_state, req_pri};

   if (STAT_FMT == FMT_NONE) begin : g_none
      assign stat_word = '0;
      assign pri_view  = cur_state;
   end else if (STAT_FMT == FMT_NARROW4) begin : g_narrow
      always_comb begin
         stat_word = '0;
         stat_word[NARROW_LSB +: NARROW_W] = cur_state[NARROW_W-1:0];
      end
      assign pri_view = req_pri;
   end else begin : g_wide
      always_comb begin
         stat_word = '0;
         stat_word[WIDE_LSB +: WIDE_W] = cur_state[WIDE_W-1:0];
      end
      assign pri_view = req_pri;
   end
endmodule

// File: rtl/cluster_pstate_regblk.sv
module cluster_pstate_regblk
   import pstate_pkg::*;
#(
   parameter int        ADDR_W       = 8,
   parameter int        TRANS_CYCLES = 4,
   parameter stat_fmt_e STAT_FMT     = FMT_WIDE5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  addr,
   input  logic               wr_en,
   input  logic [REG_W-1:0]   wr_data,
   output logic [REG_W-1:0]   rd_data,
   output logic [PS_W-1:0]    cur_state
);
   localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(CMD_OFS);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

   if (ADDR_W < 7) begin : g_bad_addr
      $error("cluster_pstate_regblk: ADDR_W too narrow for register offsets");
   end

   logic            cmd_hit, stat_hit, accept, set_req;
   logic            busy, finish;
   logic [PS_W-1:0] req_pri_q, req_sec_q, cur_q, pri_view;
   logic [REG_W-1:0] cmd_word, stat_word;
   logic            unused_wr_parity;

   assign unused_wr_parity = ^wr_data;

   assign cmd_hit  = (addr == CMD_A);
   assign stat_hit = (addr == STAT_A);
   assign accept   = wr_en && cmd_hit && !busy;
   assign set_req  = accept && wr_data[SET_BIT];

   pstate_timer #(.TRANS_CYCLES(TRANS_CYCLES)) timer_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (set_req),
      .busy   (busy),
      .finish (finish)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_pri_q <= '0;
         req_sec_q <= '0;
         cur_q     <= '0;
      end else begin
         if (accept) begin
            req_pri_q <= wr_data[PRI_LSB +: PS_W];
            req_sec_q <= wr_data[SEC_LSB +: PS_W];
         end
         if (finish) begin
            cur_q <= req_pri_q;
         end
      end
   end

   pstate_status_fmt #(.STAT_FMT(STAT_FMT)) fmt_i (
      .cur_state (cur_q),
      .req_pri   (req_pri_q),
      .stat_word (stat_word),
      .pri_view  (pri_view)
   );

   always_comb begin
      cmd_word                    = '0;
      cmd_word[BUSY_BIT]          = busy;
      cmd_word[SEC_LSB +: PS_W]   = req_sec_q;
      cmd_word[PRI_LSB +: PS_W]   = pri_view;
   end

   always_comb begin
      if (cmd_hit)       rd_data = cmd_word;
      else if (stat_hit) rd_data = stat_word;
      else               rd_data = '0;
   end

   assign cur_state = cur_q;
endmodule

// File: rtl/pstate_chk.sv
module pstate_chk
   import pstate_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int TRANS_CYCLES = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic              set_bit,
   input logic              busy,
   input logic [PS_W-1:0]   cur_state,
   input logic [PS_W-1:0]   req_pri,
   input logic [PS_W-1:0]   req_sec
);
   localparam int CW = $clog2(TRANS_CYCLES + 1) + 1;
   localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(CMD_OFS);

   logic [CW-1:0] win_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n)    win_cnt <= '0;
      else if (busy) win_cnt <= win_cnt + 1'b1;
      else           win_cnt <= '0;
   end

   // R3
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wr_en && addr == CMD_A && set_bit));

   // R3
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> win_cnt == CW'(TRANS_CYCLES));

   // R3
   busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> win_cnt < CW'(TRANS_CYCLES));

   // R4
   state_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cur_state) |-> $fell(busy));

   // R5
   noset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == CMD_A && !set_bit && !busy) |=> !busy);

   // R6
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_en && addr == CMD_A) |=> $stable(req_pri) && $stable(req_sec));

   // R8
   stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr != CMD_A) |=> $stable(req_pri) && $stable(req_sec));
endmodule

bind cluster_pstate_regblk pstate_chk #(
   .ADDR_W       (ADDR_W),
   .TRANS_CYCLES (TRANS_CYCLES)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .addr      (addr),
   .wr_en     (wr_en),
   .set_bit   (wr_data[pstate_pkg::SET_BIT]),
   .busy      (busy),
   .cur_state (cur_q),
   .req_pri   (req_pri_q),
   .req_sec   (req_sec_q)
);

// File: tb/cluster_pstate_regblk_tb_top.sv
`timescale 1ns/1ps
module cluster_pstate_regblk_tb_top;
   import pstate_pkg::*;

   localparam int TC = 5;
   localparam logic [7:0] A_CMD  = 8'h20;
   localparam logic [7:0] A_STAT = 8'h50;
   localparam logic [7:0] A_OTH  = 8'h30;

   // {apply, primary, secondary, expected active state}
   localparam logic [15:0] VEC [8] = '{
      {1'b1, 5'd3,  5'd1,  5'd3},
      {1'b0, 5'd9,  5'd2,  5'd3},
      {1'b1, 5'd31, 5'd31, 5'd31},
      {1'b1, 5'd16, 5'd0,  5'd16},
      {1'b0, 5'd0,  5'd7,  5'd16},
      {1'b1, 5'd0,  5'd5,  5'd0},
      {1'b1, 5'd21, 5'd10, 5'd21},
      {1'b1, 5'd15, 5'd15, 5'd15}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [63:0] wr_data = '0;
   logic [63:0] rd_w, rd_n, rd_o;
   logic [4:0]  cs_w, cs_n, cs_o;

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   cluster_pstate_regblk #(.ADDR_W(8), .TRANS_CYCLES(TC), .STAT_FMT(FMT_WIDE5)) dut_i (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_w), .cur_state(cs_w));
   cluster_pstate_regblk #(.ADDR_W(8), .TRANS_CYCLES(TC), .STAT_FMT(FMT_NARROW4)) dut_nar_i (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_n), .cur_state(cs_n));
   cluster_pstate_regblk #(.ADDR_W(8), .TRANS_CYCLES(TC), .STAT_FMT(FMT_NONE)) dut_non_i (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_o), .cur_state(cs_o));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [7:0] a, input logic [63:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input logic [7:0] a);
      addr = a;
      #0.5;
   endtask

   function automatic logic [63:0] cmd_val(input logic set, input logic [4:0] p,
                                           input logic [4:0] s);
      logic [63:0] w = '0;
      w[SET_BIT] = set;
      w[SEC_LSB +: 5] = s;
      w[PRI_LSB +: 5] = p;
      w[40] = 1'b1;  // stray high bit, must never read back
      w[27] = 1'b1;
      return w;
   endfunction

   function automatic logic [63:0] cmd_exp(input logic busy, input logic [4:0] p,
                                           input logic [4:0] s);
      logic [63:0] w = '0;
      w[31] = busy;
      w[16:12] = s;
      w[4:0] = p;
      return w;
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [4:0] prev_cur;
      logic [4:0] last_pri;
      logic [4:0] last_sec;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_CMD);
      chk("R1 cmd after reset", rd_w, 64'h0);
      rd(A_STAT);
      chk("R1 status after reset", rd_w, 64'h0);
      chk("R1 active state after reset", {59'h0, cs_w}, 64'h0);

      prev_cur = 5'd0;
      last_pri = 5'd0;
      last_sec = 5'd0;
      for (int i = 0; i < 8; i++) begin
         logic       v_set;
         logic [4:0] v_pri, v_sec, v_exp;
         {v_set, v_pri, v_sec, v_exp} = VEC[i];
         do_write(A_CMD, cmd_val(v_set, v_pri, v_sec));
         last_pri = v_pri;
         last_sec = v_sec;
         if (v_set) begin
            rd(A_CMD);
            chk("R3 busy after apply", {63'h0, rd_w[31]}, 64'h1);
            chk("R4 state held while busy", {59'h0, cs_w}, {59'h0, prev_cur});
            for (int k = 1; k < TC; k++) @(negedge clk);
            rd(A_CMD);
            chk("R3 busy on last cycle", {63'h0, rd_w[31]}, 64'h1);
            chk("R4 state held on last busy cycle", {59'h0, cs_w}, {59'h0, prev_cur});
            @(negedge clk);
         end
         rd(A_CMD);
         chk(v_set ? "R3 busy cleared" : "R5 no transition", {63'h0, rd_w[31]}, 64'h0);
         chk(v_set ? "R4 state applied" : "R5 state unchanged", {59'h0, cs_w}, {59'h0, v_exp});
         chk("R2 cmd readback", rd_w, cmd_exp(1'b0, last_pri, last_sec));
         chk("R7 none fmt cmd shows active", rd_o, cmd_exp(1'b0, v_exp, last_sec));
         rd(A_STAT);
         chk("R7 wide status", rd_w, {54'h0, v_exp, 5'h0});
         chk("R7 narrow status", rd_n, {56'h0, v_exp[3:0], 4'h0});
         chk("R7 none status", rd_o, 64'h0);
         prev_cur = v_exp;
      end
      // prev_cur = 15, last sec = 15

      // R6: second apply during busy is dropped
      do_write(A_CMD, cmd_val(1'b1, 5'd7, 5'd3));
      do_write(A_CMD, cmd_val(1'b1, 5'd12, 5'd9));
      for (int k = 0; k < 20; k++) begin
         rd(A_CMD);
         if (!rd_w[31]) break;
         @(negedge clk);
      end
      rd(A_CMD);
      chk("R6 first request kept", {59'h0, cs_w}, 64'd7);
      chk("R6 ignored write not stored", rd_w, cmd_exp(1'b0, 5'd7, 5'd3));
      repeat (2 * TC) @(negedge clk);
      chk("R6 dropped state never applied", {59'h0, cs_w}, 64'd7);

      // R9: apply right after busy falls
      do_write(A_CMD, cmd_val(1'b1, 5'd4, 5'd1));
      for (int k = 1; k < TC; k++) @(negedge clk);
      @(negedge clk);
      // now in the cycle after busy fell
      chk("R9 first transition done", {59'h0, cs_w}, 64'd4);
      addr = A_CMD; wr_data = cmd_val(1'b1, 5'd26, 5'd2); wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
      rd(A_CMD);
      chk("R9 immediate restart busy", {63'h0, rd_w[31]}, 64'h1);
      for (int k = 1; k < TC; k++) @(negedge clk);
      @(negedge clk);
      chk("R9 second state applied", {59'h0, cs_w}, 64'd26);

      // R8: writes elsewhere have no effect, other reads are zero
      do_write(A_STAT, cmd_val(1'b1, 5'd20, 5'd20));
      rd(A_CMD);
      chk("R8 status write no busy", {63'h0, rd_w[31]}, 64'h0);
      chk("R8 status write no store", rd_w, cmd_exp(1'b0, 5'd26, 5'd2));
      do_write(A_OTH, cmd_val(1'b0, 5'd11, 5'd11));
      rd(A_CMD);
      chk("R8 other write no store", rd_w, cmd_exp(1'b0, 5'd26, 5'd2));
      repeat (TC + 1) @(negedge clk);
      chk("R8 active state untouched", {59'h0, cs_w}, 64'd26);
      rd(A_OTH);
      chk("R8 other address reads zero", rd_w, 64'h0);

      // R1 reset again mid-operation
      do_write(A_CMD, cmd_val(1'b1, 5'd9, 5'd9));
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rd(A_CMD);
      chk("R1 reset clears busy and fields", rd_w, 64'h0);
      chk("R1 reset clears active state", {59'h0, cs_w}, 64'h0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule